// File: doc/BRIEF.md
# Hub Downstream Port Power and Overcurrent Controller

This block owns the single ganged power-enable that feeds the external switch for every downstream port of a USB hub. It receives already-decoded host requests: set or clear port power for one addressed port, and clear of the hub-level overcurrent change bit. It keeps a per-port record of which ports the host has powered. The power-enable is raised only by a set request and lowered only when every port has been cleared. Overcurrent turns it off at once.

A global active-low overcurrent flag from the external switch is synchronized and filtered against glitches. It then drives a hub-level overcurrent status bit and a sticky change bit, which the status reporting logic reads. The block also drives a user status LED. The LED lights while the hub is enumerated and not suspended. It blinks on a slow external tick after an overcurrent, until the host clears power on every port or the hub goes through enumeration again.

Two state machines carry the behaviour. The power machine has the states PWR_IDLE, PWR_ON and PWR_TRIP, with these transitions:
- PWR_IDLE to PWR_ON on a set request with no overcurrent.
- PWR_ON to PWR_TRIP on overcurrent.
- PWR_ON to PWR_IDLE when all ports are cleared.
- PWR_TRIP to PWR_IDLE when all ports are cleared.
- PWR_TRIP to PWR_ON on a set request once the overcurrent has gone.

The LED machine has the states LED_DARK, LED_SOLID and LED_BLINK, with these transitions:
- LED_DARK to LED_SOLID when the hub is enumerated and not suspended.
- LED_SOLID to LED_DARK on suspend or loss of enumeration.
- LED_SOLID to LED_BLINK on overcurrent onset.
- LED_BLINK to LED_SOLID when all ports are cleared.
- LED_BLINK to LED_DARK on suspend or loss of enumeration. Re-enumeration then passes through LED_DARK back to LED_SOLID.

Top module: `hub_pwr_ovc_ctrl`

## Requirements
- R1: `ovc_n` is sampled through two flops. Overcurrent counts only after the synchronized value has been low for `FILT_CYCLES` consecutive cycles. A shorter low pulse changes no output.
- R2: When overcurrent is recognized, `hub_ovc_status` goes to 1 and `hub_ovc_change` goes to 1. `pwr_en` falls in the next cycle and stays 0 while the overcurrent latch holds.
- R3: `pwr_en` rises only in the cycle after a `set_port_pwr` request, and only if no overcurrent is active.
- R4: `port_sel` value k addresses downstream port k+1 (0 to NUM_PORTS-1). `pwr_en` stays 1 while any port's power request is set. It falls only once every requested port has been cleared.
- R5: After reset, `pwr_en`, `stat_led`, `hub_ovc_status` and `hub_ovc_change` are all 0.
- R6: `stat_led` is 1 while `enumerated` is 1 and `suspend` is 0. It is 0 in the cycle after `suspend` is seen.
- R7: After an overcurrent onset while lit, `stat_led` starts at 1 and inverts on every `blink_tick` pulse.
- R8: Blinking stops and `stat_led` returns to a steady 1 once the host has cleared power on all ports.
- R9: Blinking stops when the hub is re-enumerated. `enumerated` going low darkens the LED, and going high again gives a steady 1 that ignores `blink_tick`.
- R10: `hub_ovc_change` stays 1 until a `clr_ovc_change` pulse. `hub_ovc_status` returns to 0 once `ovc_n` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset / initialization |
| ovc_n | input | 1 | Asynchronous global overcurrent flag, low = fault |
| set_port_pwr | input | 1 | One-cycle request: power the addressed port |
| clr_port_pwr | input | 1 | One-cycle request: unpower the addressed port |
| port_sel | input | PSEL_W | Addressed port index (k = port k+1) |
| clr_ovc_change | input | 1 | One-cycle request: clear the overcurrent change bit |
| enumerated | input | 1 | Hub is configured by the host |
| suspend | input | 1 | Hub is in suspend |
| blink_tick | input | 1 | Slow one-cycle tick for LED blinking |
| pwr_en | output | 1 | Ganged port power-switch enable |
| stat_led | output | 1 | User status LED drive |
| hub_ovc_status | output | 1 | Hub overcurrent status bit |
| hub_ovc_change | output | 1 | Hub overcurrent change bit |

## Verification
The bench builds the block with `NUM_PORTS` = 4 and `FILT_CYCLES` = 6. The short filter window lets one test fit a pulse just under the window (which must vanish) and a sustained fault (which must trip) into a few dozen cycles. Four ports give room to check that the enable survives clearing one of two powered ports, and that a set request during a fault is refused. The blink tests drive the tick by hand, so each toggle, and the lack of toggles after power-off or re-enumeration, lands on a known cycle.

// File: rtl/hpc_pkg.sv
`timescale 1ns/1ps
package hpc_pkg;

    typedef enum logic [1:0] {
        PWR_IDLE = 2'd0,
        PWR_ON   = 2'd1,
        PWR_TRIP = 2'd2
    } pwr_state_t;

    typedef enum logic [1:0] {
        LED_DARK  = 2'd0,
        LED_SOLID = 2'd1,
        LED_BLINK = 2'd2
    } led_state_t;

endpackage

// File: rtl/hpc_ovc_filter.sv
`timescale 1ns/1ps
module hpc_ovc_filter #(
    parameter int FILT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovc_n_async,
    output logic ovc_active,
    output logic ovc_onset
);
    localparam int CNT_W = $clog2(FILT_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_CYCLES);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] low_cnt_q;
    logic             active_d_q;
    logic             low_seen;

    // two-stage synchronizer, idles high (no fault)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], ovc_n_async};
        end
    end

    assign low_seen = ~sync_q[1];

    // count consecutive low samples, saturate at the window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt_q <= '0;
        end else if (!low_seen) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != CNT_MAX) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign ovc_active = (low_cnt_q == CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_d_q <= 1'b0;
        end else begin
            active_d_q <= ovc_active;
        end
    end

    assign ovc_onset = ovc_active & ~active_d_q;

endmodule

// File: rtl/hpc_port_req.sv
`timescale 1ns/1ps
module hpc_port_req #(
    parameter int NUM_PORTS = 4,
    parameter int PSEL_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_req,
    input  logic              clr_req,
    input  logic [PSEL_W-1:0] sel,
    output logic              any_req
);
    logic [NUM_PORTS-1:0] req_q;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        logic hit;
        assign hit = (sel == PSEL_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                req_q[g] <= 1'b0;
            end else if (set_req && hit) begin
                req_q[g] <= 1'b1;
            end else if (clr_req && hit) begin
                req_q[g] <= 1'b0;
            end
        end
    end

    assign any_req = |req_q;

endmodule

// File: rtl/hpc_power_fsm.sv
`timescale 1ns/1ps
module hpc_power_fsm
    import hpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic ovc_active,
    input  logic any_req,
    output logic pwr_en
);
    pwr_state_t state_q;
    pwr_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_IDLE: begin
                if (set_req && !ovc_active) state_d = PWR_ON;
            end
            PWR_ON: begin
                if (ovc_active)      state_d = PWR_TRIP;
                else if (!any_req)   state_d = PWR_IDLE;
            end
            PWR_TRIP: begin
                if (!any_req)                      state_d = PWR_IDLE;
                else if (set_req && !ovc_active)   state_d = PWR_ON;
            end
            default: state_d = PWR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PWR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        pwr_en = (state_q == PWR_ON);
    end

endmodule

// File: rtl/hpc_led_fsm.sv
`timescale 1ns/1ps
module hpc_led_fsm
    import hpc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enumerated,
    input  logic suspend,
    input  logic ovc_onset,
    input  logic any_req,
    input  logic blink_tick,
    output logic stat_led
);
    led_state_t state_q;
    led_state_t state_d;
    logic       phase_q;
    logic       awake;

    assign awake = enumerated & ~suspend;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LED_DARK: begin
                if (awake) state_d = LED_SOLID;
            end
            LED_SOLID: begin
                if (!awake)         state_d = LED_DARK;
                else if (ovc_onset) state_d = LED_BLINK;
            end
            LED_BLINK: begin
                if (!awake)         state_d = LED_DARK;
                else if (!any_req)  state_d = LED_SOLID;
            end
            default: state_d = LED_DARK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LED_DARK;
        end else begin
            state_q <= state_d;
        end
    end

    // blink phase: held lit outside blinking, inverts per tick inside
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b1;
        end else if (state_q != LED_BLINK) begin
            phase_q <= 1'b1;
        end else if (blink_tick) begin
            phase_q <= ~phase_q;
        end
    end

    always_comb begin
        unique case (state_q)
            LED_SOLID: stat_led = 1'b1;
            LED_BLINK: stat_led = phase_q;
            default:   stat_led = 1'b0;
        endcase
    end

endmodule

// File: rtl/hub_pwr_ovc_ctrl.sv
`timescale 1ns/1ps
module hub_pwr_ovc_ctrl #(
    parameter int NUM_PORTS   = 4,
    parameter int FILT_CYCLES = 16,
    parameter int PSEL_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ovc_n,
    input  logic              set_port_pwr,
    input  logic              clr_port_pwr,
    input  logic [PSEL_W-1:0] port_sel,
    input  logic              clr_ovc_change,
    input  logic              enumerated,
    input  logic              suspend,
    input  logic              blink_tick,
    output logic              pwr_en,
    output logic              stat_led,
    output logic              hub_ovc_status,
    output logic              hub_ovc_change
);
    logic ovc_active;
    logic ovc_onset;
    logic any_req;
    logic change_q;

    hpc_ovc_filter #(
        .FILT_CYCLES (FILT_CYCLES)
    ) i_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .ovc_n_async (ovc_n),
        .ovc_active  (ovc_active),
        .ovc_onset   (ovc_onset)
    );

    hpc_port_req #(
        .NUM_PORTS (NUM_PORTS),
        .PSEL_W    (PSEL_W)
    ) i_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (set_port_pwr),
        .clr_req (clr_port_pwr),
        .sel     (port_sel),
        .any_req (any_req)
    );

    hpc_power_fsm i_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_req    (set_port_pwr),
        .ovc_active (ovc_active),
        .any_req    (any_req),
        .pwr_en     (pwr_en)
    );

    hpc_led_fsm i_led (
        .clk        (clk),
        .rst_n      (rst_n),
        .enumerated (enumerated),
        .suspend    (suspend),
        .ovc_onset  (ovc_onset),
        .any_req    (any_req),
        .blink_tick (blink_tick),
        .stat_led   (stat_led)
    );

    // sticky change bit: a new onset wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            change_q <= 1'b0;
        end else if (ovc_onset) begin
            change_q <= 1'b1;
        end else if (clr_ovc_change) begin
            change_q <= 1'b0;
        end
    end

    assign hub_ovc_status = ovc_active;
    assign hub_ovc_change = change_q;

endmodule

// File: rtl/hpc_checker.sv
`timescale 1ns/1ps
module hpc_checker (
    input logic clk,
    input logic rst_n,
    input logic set_port_pwr,
    input logic clr_ovc_change,
    input logic suspend,
    input logic pwr_en,
    input logic stat_led,
    input logic hub_ovc_status,
    input logic hub_ovc_change
);

    AST_OVC_KILLS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        hub_ovc_status |=> !pwr_en); // R2

    AST_OVC_SETS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hub_ovc_status) |=> hub_ovc_change); // R2

    AST_POWER_NEEDS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> $past(set_port_pwr)); // R3

    AST_CHANGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (hub_ovc_change && !clr_ovc_change) |=> hub_ovc_change); // R10

    AST_SUSPEND_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        suspend |=> !stat_led); // R6

endmodule

bind hub_pwr_ovc_ctrl hpc_checker i_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .set_port_pwr   (set_port_pwr),
    .clr_ovc_change (clr_ovc_change),
    .suspend        (suspend),
    .pwr_en         (pwr_en),
    .stat_led       (stat_led),
    .hub_ovc_status (hub_ovc_status),
    .hub_ovc_change (hub_ovc_change)
);

// File: tb/test_hub_pwr_ovc_ctrl.sv
`timescale 1ns/1ps
module test_hub_pwr_ovc_ctrl;
    localparam int NP = 4;
    localparam int FC = 6;
    localparam int SW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ovc_n = 1'b1;
    logic set_port_pwr = 1'b0;
    logic clr_port_pwr = 1'b0;
    logic [SW-1:0] port_sel = '0;
    logic clr_ovc_change = 1'b0;
    logic enumerated = 1'b0;
    logic suspend = 1'b0;
    logic blink_tick = 1'b0;
    logic pwr_en, stat_led, hub_ovc_status, hub_ovc_change;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hub_pwr_ovc_ctrl #(
        .NUM_PORTS   (NP),
        .FILT_CYCLES (FC),
        .PSEL_W      (SW)
    ) i_hub_pwr_ovc_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .ovc_n          (ovc_n),
        .set_port_pwr   (set_port_pwr),
        .clr_port_pwr   (clr_port_pwr),
        .port_sel       (port_sel),
        .clr_ovc_change (clr_ovc_change),
        .enumerated     (enumerated),
        .suspend        (suspend),
        .blink_tick     (blink_tick),
        .pwr_en         (pwr_en),
        .stat_led       (stat_led),
        .hub_ovc_status (hub_ovc_status),
        .hub_ovc_change (hub_ovc_change)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pwr(input int p);
        @(negedge clk); port_sel = SW'(p); set_port_pwr = 1'b1;
        @(negedge clk); set_port_pwr = 1'b0;
    endtask

    task automatic clr_pwr(input int p);
        @(negedge clk); port_sel = SW'(p); clr_port_pwr = 1'b1;
        @(negedge clk); clr_port_pwr = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); blink_tick = 1'b1;
        @(negedge clk); blink_tick = 1'b0;
    endtask

    task automatic clear_change();
        @(negedge clk); clr_ovc_change = 1'b1;
        @(negedge clk); clr_ovc_change = 1'b0;
    endtask

    task automatic t_reset();
        cyc(2);
        chk("R5", "pwr_en", pwr_en, 1'b0);
        chk("R5", "stat_led", stat_led, 1'b0);
        chk("R5", "status", hub_ovc_status, 1'b0);
        chk("R5", "change", hub_ovc_change, 1'b0);
    endtask

    task automatic t_led_enum();
        enumerated = 1'b1; cyc(2);
        chk("R6", "led lit when enumerated", stat_led, 1'b1);
        suspend = 1'b1; cyc(2);
        chk("R6", "led dark in suspend", stat_led, 1'b0);
        suspend = 1'b0; cyc(2);
        chk("R6", "led lit after resume", stat_led, 1'b1);
    endtask

    task automatic t_gang_power();
        cyc(4);
        chk("R3", "no power without request", pwr_en, 1'b0);
        set_pwr(0); cyc(1);
        chk("R3", "power after set", pwr_en, 1'b1);
        set_pwr(2); clr_pwr(0); cyc(2);
        chk("R4", "power held by port 3", pwr_en, 1'b1);
        clr_pwr(2); cyc(2);
        chk("R4", "power off when all cleared", pwr_en, 1'b0);
        cyc(5);
        chk("R3", "power stays off", pwr_en, 1'b0);
    endtask

    task automatic t_glitch();
        set_pwr(1); cyc(1);
        ovc_n = 1'b0; cyc(FC - 2);
        ovc_n = 1'b1; cyc(FC + 6);
        chk("R1", "short pulse status", hub_ovc_status, 1'b0);
        chk("R1", "short pulse change", hub_ovc_change, 1'b0);
        chk("R1", "short pulse power", pwr_en, 1'b1);
    endtask

    task automatic t_trip();
        ovc_n = 1'b0; cyc(FC + 6);
        chk("R2", "status on fault", hub_ovc_status, 1'b1);
        chk("R2", "change on fault", hub_ovc_change, 1'b1);
        chk("R2", "power off on fault", pwr_en, 1'b0);
        chk("R7", "blink starts lit", stat_led, 1'b1);
        set_pwr(3); cyc(2);
        chk("R3", "set refused during fault", pwr_en, 1'b0);
        tick();
        chk("R7", "blink first toggle", stat_led, 1'b0);
        tick();
        chk("R7", "blink second toggle", stat_led, 1'b1);
        ovc_n = 1'b1; cyc(6);
        chk("R10", "status follows input", hub_ovc_status, 1'b0);
        chk("R10", "change sticky", hub_ovc_change, 1'b1);
        chk("R2", "power stays latched off", pwr_en, 1'b0);
        clr_pwr(1); clr_pwr(3); cyc(2);
        tick();
        chk("R8", "steady after power cleared", stat_led, 1'b1);
        tick();
        chk("R8", "still steady", stat_led, 1'b1);
        clear_change();
        chk("R10", "change cleared by request", hub_ovc_change, 1'b0);
    endtask

    task automatic t_reenum();
        set_pwr(0); cyc(1);
        chk("R3", "re-power after fault gone", pwr_en, 1'b1);
        ovc_n = 1'b0; cyc(FC + 6);
        chk("R2", "second trip power", pwr_en, 1'b0);
        tick();
        chk("R7", "blinking again", stat_led, 1'b0);
        ovc_n = 1'b1;
        enumerated = 1'b0; cyc(2);
        chk("R9", "dark when unenumerated", stat_led, 1'b0);
        enumerated = 1'b1; cyc(2);
        chk("R9", "lit after re-enumeration", stat_led, 1'b1);
        tick();
        chk("R9", "no blink after re-enumeration", stat_led, 1'b1);
        cyc(4);
        set_pwr(0); cyc(1);
        chk("R3", "set re-powers from trip", pwr_en, 1'b1);
        clear_change();
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_led_enum();
        t_gang_power();
        t_glitch();
        t_trip();
        t_reenum();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule